// File: doc/BRIEF.md
# PHY Register Initialization Sequencer

This block brings a gigabit copper Ethernet PHY into a working state after reset without software. A single start pulse launches a fixed script of register transactions. The script selects the copper page and sets the pause and speed advertisement bits with read-modify-write. It then enables and restarts auto-negotiation, issues a software reset, and polls until that reset bit clears. Last, it sets the RGMII clock-delay mode on the MAC-control page and returns the page register to the copper page.

Transactions go out on a simple request port with one request outstanding at a time. A separate serial management master carries each request to the PHY and answers with a done strobe and read data. The block drives a busy level while the script runs. It gives a one-cycle completion pulse on success. If the reset poll exceeds a programmable number of attempts, it sets a sticky error flag and halts.

Top module: `phy_init_seq`

## Requirements
- R1: After reset, busy, reqValid, doneP and errFlag are all low.
- R2: A start pulse seen while idle launches the script, and busy is high from the next cycle until the script ends. A start pulse seen while busy has no effect.
- R3: A request holds reqValid high, with reqWrite, reqPhy, reqReg and reqWdata stable, until the cycle rspDone is sampled. reqValid is then low for at least one cycle. Every request carries the phyAddr value captured at start.
- R4: Register 22 is the page selector. It is written with 0 before any copper register access and with 2 before register 21. After the register 21 update it is written with 0 again.
- R5: Register 4 is read, then written back with mask 0x0DE0 ORed in (bits 11, 10, 8, 7, 6, 5). Every other bit keeps the value that was read.
- R6: Register 9 is read, then written back with mask 0x0300 ORed in (bits 9 and 8). Every other bit keeps the value that was read.
- R7: Register 0 is read and written back with 0x1200 (bits 12 and 9) ORed in as one write. A second read-modify-write of register 0 then ORs in 0x8000 (bit 15).
- R8: After the bit-15 write, register 0 is read repeatedly until a read returns bit 15 low. The script then moves on.
- R9: Each poll read that returns bit 15 high counts as a busy read. When that count reaches pollLimit (a limit of 0 acts as 1), errFlag goes high, busy drops, no doneP is given and no further request is issued. errFlag stays high until the next accepted start clears it.
- R10: txDelayOff is captured at start. When it is 0, register 21 is written back with bits 5 and 4 set. When it is 1, bit 5 is set and bit 4 is cleared. All other bits keep the values that were read.
- R11: On success, doneP is high for exactly one cycle: the cycle after the final rspDone, in which busy is already low.
- R12: The transactions come in this order: page 0, R/W reg 4, R/W reg 9, R/W reg 0 (0x1200), R/W reg 0 (0x8000), poll reads of reg 0, page 2, R/W reg 21, page 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches the script when idle |
| txDelayOff | input | 1 | Delay mode: 0 keeps both delays on, 1 turns the TX delay off |
| phyAddr | input | PHY_AW | PHY address, captured at start |
| pollLimit | input | POLL_W | Busy reads allowed in the reset poll; held stable while running |
| reqValid | output | 1 | Register transaction request |
| reqWrite | output | 1 | 1 for a write, 0 for a read |
| reqPhy | output | PHY_AW | PHY address of the request |
| reqReg | output | 5 | Register address of the request |
| reqWdata | output | 16 | Write data |
| rspRdata | input | 16 | Read data, valid with rspDone |
| rspDone | input | 1 | Transaction complete strobe |
| busy | output | 1 | Script in progress |
| doneP | output | 1 | One-cycle success pulse |
| errFlag | output | 1 | Sticky reset-poll timeout flag |

## Verification
The bench models the PHY register file with pages, so every read-modify-write is checked against the value it actually read. This covers preserved foreign bits. A design that wrote constants would clobber them, and one that forgot to select page 2 would update the wrong register 21. The reset poll is driven with busy counts just below, at, and far above pollLimit, including limits of 0 and 1. An off-by-one counter would either halt one read early or issue one extra read, and both show up in the request stream. A start pulse in mid-run and a flip of txDelayOff after start are also applied; a design that restarted on the pulse or read the mode live would emit a different transaction list. Busy, doneP and errFlag are compared every cycle, which catches a done pulse given after a timeout or an error flag that clears by itself.

// File: rtl/phy_init_pkg.sv
package phy_init_pkg;

  localparam int REG_W = 16;
  localparam int STEP_W = 4;
  localparam int NUM_STEPS = 14;
  localparam logic [STEP_W-1:0] POLL_STEP = 4'd9;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);
  localparam logic [4:0] PAGE_REG = 5'd22;
  localparam logic [4:0] MACCTL_REG = 5'd21;
  localparam int RST_BIT = 15;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_GAP} seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic armMode;
    logic capture;
    logic pollClr;
    logic pollInc;
  } dpStrobe_t;

  // one script step; for non-RMW writes setMask is the literal data
  typedef struct packed {
    logic isWrite;
    logic isRmw;
    logic [4:0] regAddr;
    logic [REG_W-1:0] setMask;
    logic [REG_W-1:0] clrMask;
  } stepInfo_t;

  function automatic stepInfo_t stepLookup(input logic [STEP_W-1:0] idx, input logic txOff);
    stepInfo_t s;
    s = '{isWrite: 1'b0, isRmw: 1'b0, regAddr: 5'd0, setMask: '0, clrMask: '0};
    case (idx)
      4'd0:  begin s.isWrite = 1'b1; s.regAddr = PAGE_REG; s.setMask = 16'h0000; end
      4'd1:  s.regAddr = 5'd4;
      4'd2:  begin s.isWrite = 1'b1; s.isRmw = 1'b1; s.regAddr = 5'd4; s.setMask = 16'h0DE0; end
      4'd3:  s.regAddr = 5'd9;
      4'd4:  begin s.isWrite = 1'b1; s.isRmw = 1'b1; s.regAddr = 5'd9; s.setMask = 16'h0300; end
      4'd5:  s.regAddr = 5'd0;
      4'd6:  begin s.isWrite = 1'b1; s.isRmw = 1'b1; s.regAddr = 5'd0; s.setMask = 16'h1200; end
      4'd7:  s.regAddr = 5'd0;
      4'd8:  begin s.isWrite = 1'b1; s.isRmw = 1'b1; s.regAddr = 5'd0; s.setMask = 16'h8000; end
      4'd9:  s.regAddr = 5'd0;
      4'd10: begin s.isWrite = 1'b1; s.regAddr = PAGE_REG; s.setMask = 16'h0002; end
      4'd11: s.regAddr = MACCTL_REG;
      4'd12: begin
        s.isWrite = 1'b1; s.isRmw = 1'b1; s.regAddr = MACCTL_REG;
        s.setMask = txOff ? 16'h0020 : 16'h0030;
        s.clrMask = txOff ? 16'h0010 : 16'h0000;
      end
      4'd13: begin s.isWrite = 1'b1; s.regAddr = PAGE_REG; s.setMask = 16'h0000; end
      default: s.regAddr = 5'd0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/phy_init_dp.sv
module phy_init_dp
  import phy_init_pkg::*;
#(
  parameter int PHY_AW = 5,
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [STEP_W-1:0] stepIdx,
  input  logic              txDelayOff,
  input  logic [PHY_AW-1:0] phyAddr,
  input  logic [POLL_W-1:0] pollLimit,
  input  logic [REG_W-1:0]  rspRdata,
  input  logic              rspDone,
  input  logic              reqValid,
  output logic              reqWrite,
  output logic [PHY_AW-1:0] reqPhy,
  output logic [4:0]        reqReg,
  output logic [REG_W-1:0]  reqWdata,
  output logic              pollLast
);

  localparam int CNT_W = POLL_W + 1;

  logic              modeQ;
  logic [PHY_AW-1:0] phyQ;
  logic [REG_W-1:0]  rdBuf;
  logic [POLL_W-1:0] pollCnt;
  logic [7:0]        pageSeen;
  logic [CNT_W-1:0]  nextCnt;
  stepInfo_t         info;

  assign info     = stepLookup(stepIdx, modeQ);
  assign reqWrite = info.isWrite;
  assign reqReg   = info.regAddr;
  assign reqPhy   = phyQ;
  assign reqWdata = info.isRmw ? ((rdBuf | info.setMask) & ~info.clrMask) : info.setMask;
  assign nextCnt  = {1'b0, pollCnt} + CNT_W'(1);
  assign pollLast = nextCnt >= {1'b0, pollLimit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= 1'b0;
      phyQ    <= '0;
      rdBuf   <= '0;
      pollCnt <= '0;
    end else begin
      if (strobe.armMode) begin
        modeQ <= txDelayOff;
        phyQ  <= phyAddr;
      end
      if (strobe.capture && !info.isWrite) rdBuf <= rspRdata;
      if (strobe.pollClr) pollCnt <= '0;
      else if (strobe.pollInc) pollCnt <= nextCnt[POLL_W-1:0];
    end
  end

  // page actually selected in the PHY, as seen by completed writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pageSeen <= 8'd0;
    else if (reqValid && rspDone && reqWrite && reqReg == PAGE_REG) pageSeen <= reqWdata[7:0];
  end

  assert_hold_fields_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !rspDone) |=> ($stable(reqReg) && $stable(reqWdata) && $stable(reqWrite) && $stable(reqPhy)));

  assert_copper_page_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReg != PAGE_REG && reqReg != MACCTL_REG) |-> (pageSeen == 8'd0));

  assert_mac_page_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReg == MACCTL_REG) |-> (pageSeen == 8'd2));

endmodule

// File: rtl/phy_init_ctrl.sv
module phy_init_ctrl
  import phy_init_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              rspDone,
  input  logic              rstBitSeen,
  input  logic              pollLast,
  output dpStrobe_t         strobe,
  output logic [STEP_W-1:0] stepIdx,
  output logic              reqValid,
  output logic              busy,
  output logic              doneP,
  output logic              errFlag
);

  seqState_t state;
  logic      launch;
  logic      pollStep;

  assign launch   = (state == S_IDLE) && start;
  assign pollStep = (stepIdx == POLL_STEP);
  assign reqValid = (state == S_REQ);
  assign busy     = (state != S_IDLE);

  always_comb begin
    strobe         = '0;
    strobe.armMode = launch;
    strobe.pollClr = launch;
    strobe.capture = reqValid && rspDone;
    strobe.pollInc = reqValid && rspDone && pollStep && rstBitSeen && !pollLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepIdx <= '0;
      doneP   <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      doneP <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state   <= S_REQ;
          stepIdx <= '0;
          errFlag <= 1'b0;
        end
        S_REQ: if (rspDone) begin
          if (pollStep && rstBitSeen) begin
            if (pollLast) begin
              errFlag <= 1'b1;
              state   <= S_IDLE;
            end else begin
              state <= S_GAP;
            end
          end else if (stepIdx == LAST_STEP) begin
            doneP <= 1'b1;
            state <= S_IDLE;
          end else begin
            stepIdx <= stepIdx + 1'b1;
            state   <= S_GAP;
          end
        end
        S_GAP: state <= S_REQ;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_gap_after_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && rspDone) |=> !reqValid);

  assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    doneP |-> !busy);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP);

  assert_err_halts_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> (!busy && !doneP));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !start) |=> errFlag);

  assert_step_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !rspDone) |=> (busy && $stable(stepIdx)));

endmodule

// File: rtl/phy_init_seq.sv
module phy_init_seq
  import phy_init_pkg::*;
#(
  parameter int PHY_AW = 5,
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              txDelayOff,
  input  logic [PHY_AW-1:0] phyAddr,
  input  logic [POLL_W-1:0] pollLimit,
  output logic              reqValid,
  output logic              reqWrite,
  output logic [PHY_AW-1:0] reqPhy,
  output logic [4:0]        reqReg,
  output logic [15:0]       reqWdata,
  input  logic [15:0]       rspRdata,
  input  logic              rspDone,
  output logic              busy,
  output logic              doneP,
  output logic              errFlag
);

  dpStrobe_t         strobe;
  logic [STEP_W-1:0] stepIdx;
  logic              pollLast;

  phy_init_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .rspDone    (rspDone),
    .rstBitSeen (rspRdata[RST_BIT]),
    .pollLast   (pollLast),
    .strobe     (strobe),
    .stepIdx    (stepIdx),
    .reqValid   (reqValid),
    .busy       (busy),
    .doneP      (doneP),
    .errFlag    (errFlag)
  );

  phy_init_dp #(
    .PHY_AW (PHY_AW),
    .POLL_W (POLL_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .stepIdx    (stepIdx),
    .txDelayOff (txDelayOff),
    .phyAddr    (phyAddr),
    .pollLimit  (pollLimit),
    .rspRdata   (rspRdata),
    .rspDone    (rspDone),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqPhy     (reqPhy),
    .reqReg     (reqReg),
    .reqWdata   (reqWdata),
    .pollLast   (pollLast)
  );

endmodule

// File: tb/phy_init_seq_tb.sv
module phy_init_seq_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        txDelayOff = 1'b0;
  logic [4:0]  phyAddr = '0;
  logic [15:0] pollLimit = 16'd8;
  logic        reqValid, reqWrite, busy, doneP, errFlag;
  logic [4:0]  reqPhy, reqReg;
  logic [15:0] reqWdata;
  logic [15:0] rspRdata = '0;
  logic        rspDone = 1'b0;

  phy_init_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .txDelayOff(txDelayOff),
    .phyAddr(phyAddr), .pollLimit(pollLimit),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqPhy(reqPhy), .reqReg(reqReg),
    .reqWdata(reqWdata), .rspRdata(rspRdata), .rspDone(rspDone),
    .busy(busy), .doneP(doneP), .errFlag(errFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit    wr;
    int    rg;
    int    setm;
    int    clrm;
    int    val;
    string tag;
  } expTx_t;

  expTx_t      expQ[$];
  logic [15:0] mdl [0:3][0:31];
  int          page;
  int          busyLeft;
  int          cfgBusy;
  int          cfgLat;
  int          waitCnt;
  bit          expBusy;
  bit          expOk;
  bit          endPending;
  int          checks;
  int          errors;
  logic [4:0]  cfgPhy;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic initModel(input logic [15:0] r0, input logic [15:0] r4,
                           input logic [15:0] r9, input logic [15:0] r21);
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 32; r++) mdl[p][r] = 16'(p * 256 + r);
    mdl[0][0] = r0; mdl[0][4] = r4; mdl[0][9] = r9; mdl[2][21] = r21;
    page = 0;
  endtask

  task automatic pushTx(input bit wr, input int rg, input int setm, input int clrm,
                        input int val, input string tag);
    expTx_t e;
    e.wr = wr; e.rg = rg; e.setm = setm; e.clrm = clrm; e.val = val; e.tag = tag;
    expQ.push_back(e);
  endtask

  // expected transaction list from the requirements
  task automatic buildExp(input bit mode, input int k, input int lim);
    int eff;
    eff = (lim == 0) ? 1 : lim;
    expQ.delete();
    pushTx(1, 22, 0, 0, 0, "R4");
    pushTx(0, 4, 0, 0, 0, "R5");
    pushTx(1, 4, 'h0DE0, 0, 0, "R5");
    pushTx(0, 9, 0, 0, 0, "R6");
    pushTx(1, 9, 'h0300, 0, 0, "R6");
    pushTx(0, 0, 0, 0, 0, "R7");
    pushTx(1, 0, 'h1200, 0, 0, "R7");
    pushTx(0, 0, 0, 0, 0, "R7");
    pushTx(1, 0, 'h8000, 0, 0, "R7");
    if (k >= eff) begin
      for (int i = 0; i < eff; i++) pushTx(0, 0, 0, 0, 0, "R9");
      expOk = 0;
    end else begin
      for (int i = 0; i <= k; i++) pushTx(0, 0, 0, 0, 0, "R8");
      pushTx(1, 22, 0, 0, 2, "R4");
      pushTx(0, 21, 0, 0, 0, "R10");
      pushTx(1, 21, mode ? 'h20 : 'h30, mode ? 'h10 : 0, 0, "R10");
      pushTx(1, 22, 0, 0, 0, "R4");
      expOk = 1;
    end
  endtask

  task automatic serve();
    expTx_t e;
    int expData;
    logic [15:0] d;
    if (expQ.size() == 0) begin
      chk("R12 unexpected request", 1, 0);
      rspRdata = 16'h0;
      return;
    end
    e = expQ.pop_front();
    chk({e.tag, " R12 direction"}, int'(reqWrite), int'(e.wr));
    chk({e.tag, " R12 register"}, int'(reqReg), e.rg);
    chk("R3 phy address", int'(reqPhy), int'(cfgPhy));
    if (e.wr) begin
      if (e.rg == 22) expData = e.val;
      else expData = int'((mdl[page][e.rg] | 16'(e.setm)) & ~16'(e.clrm));
      chk({e.tag, " write data"}, int'(reqWdata), expData);
      if (e.rg == 22) page = expData & 3;
      else begin
        mdl[page][e.rg] = 16'(expData);
        if (e.rg == 0 && page == 0 && expData[15]) busyLeft = cfgBusy;
      end
      rspRdata = 16'hA5A5;
    end else begin
      d = mdl[page][reqReg];
      if (page == 0 && reqReg == 5'd0 && d[15]) begin
        if (busyLeft > 0) busyLeft--;
        else begin d[15] = 1'b0; mdl[0][0][15] = 1'b0; end
      end
      rspRdata = d;
    end
    if (expQ.size() == 0) endPending = 1;
  endtask

  // per-cycle reference comparison and PHY responder
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (endPending) begin
          chk("R2 busy after end", int'(busy), 0);
          chk("R11 done pulse", int'(doneP), int'(expOk));
          chk("R9 error flag", int'(errFlag), int'(!expOk));
          expBusy = 0;
          endPending = 0;
        end else begin
          chk("R2 busy", int'(busy), int'(expBusy));
          chk("R11 no stray done", int'(doneP), 0);
        end
        if (!expBusy) chk("R9 no request when idle", int'(reqValid), 0);
        if (rspDone) rspDone = 1'b0;
        else if (reqValid) begin
          if (waitCnt < cfgLat) waitCnt++;
          else begin
            waitCnt = 0;
            serve();
            rspDone = 1'b1;
          end
        end
      end
    end
  end

  task automatic pulseStart();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic runSeq(input bit mode, input int k, input int lim, input int lat,
                        input logic [4:0] phy, input bit midStart, input bit flipMode);
    cfgBusy = k; cfgLat = lat; waitCnt = 0; cfgPhy = phy;
    buildExp(mode, k, lim);
    txDelayOff = mode; phyAddr = phy; pollLimit = 16'(lim);
    pulseStart();
    expBusy = 1;
    if (flipMode) txDelayOff = !mode;
    if (midStart) begin
      repeat (6) @(posedge clk);
      pulseStart(); // R2: ignored while busy
    end
    while (expBusy) @(posedge clk);
    repeat (3) @(posedge clk);
    chk("R12 all transactions issued", expQ.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; expBusy = 0; endPending = 0; busyLeft = 0;
    cfgBusy = 0; cfgLat = 0; waitCnt = 0; cfgPhy = '0; expOk = 1;
    initModel(16'h1140, 16'h01E1, 16'h0300, 16'h0030);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 reqValid", int'(reqValid), 0);
    chk("R1 doneP", int'(doneP), 0);
    chk("R1 errFlag", int'(errFlag), 0);

    // default mode, three busy polls
    runSeq(1'b0, 3, 10, 0, 5'h03, 0, 0);
    chk("R5 reg4 final", int'(mdl[0][4]), 'h0DE1);
    chk("R7 reg0 enable+restart kept", int'(mdl[0][0] & 16'h1200), 'h1200);
    chk("R8 reset bit clear", int'(mdl[0][0][15]), 0);
    chk("R10 both delays", int'(mdl[2][21] & 16'h0030), 'h0030);
    chk("R4 final page", page, 0);

    // TX delay off, foreign bits, mid-run start, mode flipped after start
    initModel(16'h0000, 16'h0001, 16'h0000, 16'h0036);
    runSeq(1'b1, 2, 5, 2, 5'h1A, 1, 1);
    chk("R5 reg4 foreign bits kept", int'(mdl[0][4]), 'h0DE1);
    chk("R6 reg9 final", int'(mdl[0][9]), 'h0300);
    chk("R10 rx on tx off", int'(mdl[2][21]), 'h0026);

    // reset poll timeout
    initModel(16'h1140, 16'h01E1, 16'h0300, 16'h0030);
    runSeq(1'b0, 50, 4, 1, 5'h07, 0, 0);
    repeat (5) @(posedge clk);
    #1 chk("R9 error sticky", int'(errFlag), 1);
    chk("R9 mac page untouched", int'(mdl[2][21]), 'h0030);
    chk("R9 page stays copper", page, 0);

    // restart after error clears the flag and completes
    initModel(16'h1140, 16'h01E1, 16'h0300, 16'h0030);
    runSeq(1'b0, 0, 4, 1, 5'h07, 0, 0);
    chk("R9 error cleared by start", int'(errFlag), 0);

    // limit boundaries
    initModel(16'h1140, 16'h01E1, 16'h0300, 16'h0030);
    runSeq(1'b0, 1, 1, 0, 5'h01, 0, 0);
    initModel(16'h1140, 16'h01E1, 16'h0300, 16'h0030);
    runSeq(1'b1, 0, 0, 0, 5'h02, 0, 0);
    initModel(16'h1140, 16'h01E1, 16'h0300, 16'h0030);
    runSeq(1'b0, 2, 3, 1, 5'h04, 0, 0);
    initModel(16'h1140, 16'h01E1, 16'h0300, 16'h0030);
    runSeq(1'b0, 3, 3, 0, 5'h05, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule